// File: doc/BRIEF.md
# Stream Period and Interrupt Status Controller

This block follows the transfer period of a single audio stream, counted in frames, and owns the stream's status flags and interrupt line. A DMA walker reports frames moved and descriptor completions. The block tells the walker whether it may keep moving data, and decides when a period is over. It raises the buffer-complete flag once for each whole period that asked for an interrupt, and drives the stream interrupt from the flags and their enables.

When a period ends, the block proposes a new wall-clock value: the period's start stamp plus the period length in wall-clock ticks. A shared wall-clock register, held here, takes that value only when every other active stream already reports a position at or beyond it, or when a force input is high. A period that requested an interrupt stays closed after it raises buffer-complete. It reopens when software clears that flag while the stream runs. A period that requested no interrupt rolls over into the next one at once.

Top module: `strmPeriodIrq`

## Requirements
- R1: The status vector is bit 0 buffer-complete, bit 1 FIFO error, bit 2 descriptor error. A status write with a 1 in a bit clears that bit, and a 0 leaves it unchanged. An event arriving in the same cycle as the clear wins.
- R2: A descriptor completion marked for interrupt records a pending interrupt for the open period only when the interrupt-on-completion enable is high. Otherwise it has no effect on the period's outcome.
- R3: Buffer-complete is never set by a descriptor completion alone. It is set only in the cycle after the frame count reaches PERIOD_FRAMES.
- R4: When a period with a pending interrupt has reached its frame count, buffer-complete is set and the period closes only if the wall-clock commit succeeds in that cycle. Otherwise the block waits, with no interrupt, and retries every cycle.
- R5: When a period without a pending interrupt reaches its frame count, the next cycle begins a new period. Its frame count is 0 and its start stamp is the committed wall clock, or the current one if the commit was refused.
- R6: A rising edge on the run input begins a new period. The frame count becomes 0, the pending interrupt is cleared, and the start stamp takes the current wall clock.
- R7: The proposal is start stamp + PERIOD_FRAMES*TICKS_PER_FRAME. It is committed only when every peer marked active reports a time greater than or equal to it, or when the force input is high.
- R8: The transfer grant is low while run is low or the period's frame count is full. Frame increments offered while the grant is low leave the count unchanged.
- R9: A write clearing a set buffer-complete while run is high begins a new period stamped with the current wall clock. The same write with run low only clears the bit.
- R10: The interrupt is high exactly when some status bit is set together with its enable. Buffer-complete pairs with the interrupt-on-completion enable.
- R11: A FIFO-error or descriptor-error event sets its status bit whether or not the matching enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Stream run control |
| iocEn | input | 1 | Interrupt-on-completion enable |
| fifoErrEn | input | 1 | FIFO-error interrupt enable |
| descErrEn | input | 1 | Descriptor-error interrupt enable |
| frameValid | input | 1 | Frame increment valid |
| frameInc | input | INC_W | Frames moved this cycle |
| descDone | input | 1 | Descriptor completed this cycle |
| descIoc | input | 1 | Completed descriptor requests an interrupt |
| fifoErrEvt | input | 1 | FIFO error event |
| descErrEvt | input | 1 | Descriptor error event |
| stsWrEn | input | 1 | Status register write strobe |
| stsWrData | input | 3 | Status write data (1 clears) |
| wcForce | input | 1 | Commit wall clock regardless of peers |
| peerActive | input | NUM_PEERS | Peer stream active flags |
| peerTime | input | NUM_PEERS*WC_W | Peer stream positions, peer g at bits g*WC_W upward |
| status | output | 3 | Status flags |
| streamIrq | output | 1 | Stream interrupt |
| xferGrant | output | 1 | Walker may move more frames |
| periodFrames | output | FRAME_W | Frames counted in the current period |
| periodStart | output | WC_W | Start stamp of the current period |
| wallClk | output | WC_W | Shared wall-clock register |

## Verification
The bench sends a descriptor marked for interrupt halfway through a period and checks that buffer-complete does not rise until the frame count is full. A design that raised it for each descriptor would interrupt early. It blocks the wall-clock commit with a lagging active peer and checks that the period stays complete, with no flag and no grant, until the peer catches up or force is raised. A design that set the flag anyway would interrupt while the clock had not advanced. It also checks that frames offered to a closed period are dropped, that a zero write leaves flags alone, and that a clear with run low does not restart the period. A design that got these wrong would let the count run past the period or restart transfers that software had stopped.

// File: rtl/strmPeriodPkg.sv
package strmPeriodPkg;
  typedef struct packed {
    logic beginPeriod;
    logic commitWc;
    logic setBufCmp;
  } periodStrobes_t;

  localparam int STS_BUF  = 0;
  localparam int STS_FIFO = 1;
  localparam int STS_DESC = 2;
endpackage

// File: rtl/periodCtl.sv
module periodCtl
  import strmPeriodPkg::*;
#(
  parameter int WC_W      = 16,
  parameter int NUM_PEERS = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      runEn,
  input  logic                      wcForce,
  input  logic [NUM_PEERS-1:0]      peerActive,
  input  logic [NUM_PEERS*WC_W-1:0] peerTime,
  input  logic                      stsWrEn,
  input  logic                      clrBufReq,
  input  logic                      bufCmpSet,
  input  logic                      periodFull,
  input  logic                      periodClosed,
  input  logic                      irqPending,
  input  logic [WC_W-1:0]           proposal,
  output periodStrobes_t            strobes,
  output logic                      grant
);
  logic runQ;
  logic [NUM_PEERS-1:0] peerOk;
  logic commitOk, runRise, evalSlot, autoRoll, swRoll;

  always_ff @(posedge clk) begin
    if (!rstN) runQ <= 1'b0;
    else       runQ <= runEn;
  end

  for (genvar g = 0; g < NUM_PEERS; g++) begin : gPeer
    assign peerOk[g] = !peerActive[g] || (peerTime[g*WC_W +: WC_W] >= proposal);
  end

  always_comb begin
    commitOk = wcForce || (&peerOk);
    runRise  = runEn && !runQ;
    evalSlot = runEn && runQ && periodFull && !periodClosed;
    autoRoll = evalSlot && !irqPending;
    swRoll   = runEn && runQ && stsWrEn && clrBufReq && bufCmpSet;
    strobes.beginPeriod = runRise || autoRoll || swRoll;
    strobes.commitWc    = evalSlot && commitOk;
    strobes.setBufCmp   = evalSlot && irqPending && commitOk;
    grant = runEn && !periodFull;
  end
endmodule

// File: rtl/periodDp.sv
module periodDp
  import strmPeriodPkg::*;
#(
  parameter int PERIOD_FRAMES   = 8,
  parameter int TICKS_PER_FRAME = 2,
  parameter int INC_W           = 4,
  parameter int WC_W            = 16,
  parameter int FRAME_W         = $clog2(PERIOD_FRAMES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  periodStrobes_t     strobes,
  input  logic               grant,
  input  logic               frameValid,
  input  logic [INC_W-1:0]   frameInc,
  input  logic               descDone,
  input  logic               descIoc,
  input  logic               iocEn,
  input  logic               fifoErrEn,
  input  logic               descErrEn,
  input  logic               fifoErrEvt,
  input  logic               descErrEvt,
  input  logic               stsWrEn,
  input  logic [2:0]         stsWrData,
  output logic [2:0]         status,
  output logic               streamIrq,
  output logic               periodFull,
  output logic               periodClosed,
  output logic               irqPending,
  output logic [WC_W-1:0]    proposal,
  output logic [FRAME_W-1:0] periodFrames,
  output logic [WC_W-1:0]    periodStart,
  output logic [WC_W-1:0]    wallClk
);
  localparam int SUM_W = ((FRAME_W > INC_W) ? FRAME_W : INC_W) + 1;
  localparam logic [SUM_W-1:0]  FULL_SUM  = SUM_W'(PERIOD_FRAMES);
  localparam logic [WC_W-1:0]   SPAN      = WC_W'(PERIOD_FRAMES * TICKS_PER_FRAME);

  logic [SUM_W-1:0] frameSum;
  logic [2:0] clrMask;

  assign frameSum   = SUM_W'(periodFrames) + SUM_W'(frameInc);
  assign periodFull = (SUM_W'(periodFrames) == FULL_SUM);
  assign proposal   = periodStart + SPAN;
  assign clrMask    = stsWrEn ? stsWrData : 3'b000;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodFrames <= '0;
      periodStart  <= '0;
      wallClk      <= '0;
      periodClosed <= 1'b0;
      irqPending   <= 1'b0;
      status       <= '0;
    end else begin
      if (strobes.beginPeriod)
        periodFrames <= '0;
      else if (grant && frameValid)
        periodFrames <= (frameSum >= FULL_SUM) ? FRAME_W'(PERIOD_FRAMES) : FRAME_W'(frameSum);

      if (strobes.commitWc) wallClk <= proposal;

      if (strobes.beginPeriod)
        periodStart <= strobes.commitWc ? proposal : wallClk;

      if (strobes.beginPeriod)    periodClosed <= 1'b0;
      else if (strobes.setBufCmp) periodClosed <= 1'b1;

      if (strobes.beginPeriod)
        irqPending <= 1'b0;
      else if (grant && descDone && descIoc && iocEn)
        irqPending <= 1'b1;

      status[STS_BUF]  <= strobes.setBufCmp || (status[STS_BUF]  && !clrMask[STS_BUF]);
      status[STS_FIFO] <= fifoErrEvt        || (status[STS_FIFO] && !clrMask[STS_FIFO]);
      status[STS_DESC] <= descErrEvt        || (status[STS_DESC] && !clrMask[STS_DESC]);
    end
  end

  assign streamIrq = (status[STS_BUF] && iocEn) || (status[STS_FIFO] && fifoErrEn)
                   || (status[STS_DESC] && descErrEn);
endmodule

// File: rtl/strmPeriodIrq.sv
module strmPeriodIrq
  import strmPeriodPkg::*;
#(
  parameter int PERIOD_FRAMES   = 8,
  parameter int TICKS_PER_FRAME = 2,
  parameter int INC_W           = 4,
  parameter int WC_W            = 16,
  parameter int NUM_PEERS       = 2,
  parameter int FRAME_W         = $clog2(PERIOD_FRAMES + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      runEn,
  input  logic                      iocEn,
  input  logic                      fifoErrEn,
  input  logic                      descErrEn,
  input  logic                      frameValid,
  input  logic [INC_W-1:0]          frameInc,
  input  logic                      descDone,
  input  logic                      descIoc,
  input  logic                      fifoErrEvt,
  input  logic                      descErrEvt,
  input  logic                      stsWrEn,
  input  logic [2:0]                stsWrData,
  input  logic                      wcForce,
  input  logic [NUM_PEERS-1:0]      peerActive,
  input  logic [NUM_PEERS*WC_W-1:0] peerTime,
  output logic [2:0]                status,
  output logic                      streamIrq,
  output logic                      xferGrant,
  output logic [FRAME_W-1:0]        periodFrames,
  output logic [WC_W-1:0]           periodStart,
  output logic [WC_W-1:0]           wallClk
);
  periodStrobes_t strobes;
  logic periodFull, periodClosed, irqPending;
  logic [WC_W-1:0] proposal;

  periodCtl #(.WC_W(WC_W), .NUM_PEERS(NUM_PEERS)) uCtl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .wcForce(wcForce),
    .peerActive(peerActive), .peerTime(peerTime),
    .stsWrEn(stsWrEn), .clrBufReq(stsWrData[STS_BUF]), .bufCmpSet(status[STS_BUF]),
    .periodFull(periodFull), .periodClosed(periodClosed), .irqPending(irqPending),
    .proposal(proposal), .strobes(strobes), .grant(xferGrant)
  );

  periodDp #(.PERIOD_FRAMES(PERIOD_FRAMES), .TICKS_PER_FRAME(TICKS_PER_FRAME),
             .INC_W(INC_W), .WC_W(WC_W), .FRAME_W(FRAME_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .grant(xferGrant),
    .frameValid(frameValid), .frameInc(frameInc), .descDone(descDone), .descIoc(descIoc),
    .iocEn(iocEn), .fifoErrEn(fifoErrEn), .descErrEn(descErrEn),
    .fifoErrEvt(fifoErrEvt), .descErrEvt(descErrEvt),
    .stsWrEn(stsWrEn), .stsWrData(stsWrData),
    .status(status), .streamIrq(streamIrq), .periodFull(periodFull),
    .periodClosed(periodClosed), .irqPending(irqPending), .proposal(proposal),
    .periodFrames(periodFrames), .periodStart(periodStart), .wallClk(wallClk)
  );
endmodule

// File: rtl/strmPeriodIrqChk.sv
module strmPeriodIrqChk #(
  parameter int PERIOD_FRAMES = 8,
  parameter int WC_W          = 16,
  parameter int FRAME_W       = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               runEn,
  input logic               iocEn,
  input logic               fifoErrEn,
  input logic               fifoErrEvt,
  input logic               stsWrEn,
  input logic [2:0]         stsWrData,
  input logic [2:0]         status,
  input logic               streamIrq,
  input logic               xferGrant,
  input logic [FRAME_W-1:0] periodFrames,
  input logic [WC_W-1:0]    wallClk
);
  localparam logic [FRAME_W-1:0] FULL = FRAME_W'(PERIOD_FRAMES);

  a_r8_no_grant_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (periodFrames == FULL) |-> !xferGrant);

  a_r3_bufcmp_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> ($past(periodFrames) == FULL));

  a_r7_wallclk_moves_at_full: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wallClk) |-> ($past(periodFrames) == FULL));

  a_r6_run_rise_restarts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runEn) |=> (periodFrames == '0));

  a_r1_fifo_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stsWrEn && stsWrData[1] && !fifoErrEvt) |=> !status[1]);

  a_r10_fifo_irq: assert property (@(posedge clk) disable iff (!rstN)
    (status[1] && fifoErrEn) |-> streamIrq);

  a_r10_buf_irq: assert property (@(posedge clk) disable iff (!rstN)
    (status[0] && iocEn) |-> streamIrq);
endmodule

bind strmPeriodIrq strmPeriodIrqChk #(
  .PERIOD_FRAMES(PERIOD_FRAMES), .WC_W(WC_W), .FRAME_W(FRAME_W)
) uChk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .iocEn(iocEn), .fifoErrEn(fifoErrEn),
  .fifoErrEvt(fifoErrEvt), .stsWrEn(stsWrEn), .stsWrData(stsWrData),
  .status(status), .streamIrq(streamIrq), .xferGrant(xferGrant),
  .periodFrames(periodFrames), .wallClk(wallClk)
);

// File: tb/tb_strmPeriodIrq.sv
module tb_strmPeriodIrq;
  localparam int WC_W = 16;
  localparam int NP   = 2;

  logic clk = 1'b0;
  logic rstN;
  logic runEn, iocEn, fifoErrEn, descErrEn, frameValid, descDone, descIoc;
  logic fifoErrEvt, descErrEvt, stsWrEn, wcForce;
  logic [3:0] frameInc;
  logic [2:0] stsWrData;
  logic [NP-1:0] peerActive;
  logic [NP*WC_W-1:0] peerTime;
  logic [2:0] status;
  logic streamIrq, xferGrant;
  logic [3:0] periodFrames;
  logic [WC_W-1:0] periodStart, wallClk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  strmPeriodIrq dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .iocEn(iocEn), .fifoErrEn(fifoErrEn),
    .descErrEn(descErrEn), .frameValid(frameValid), .frameInc(frameInc),
    .descDone(descDone), .descIoc(descIoc), .fifoErrEvt(fifoErrEvt),
    .descErrEvt(descErrEvt), .stsWrEn(stsWrEn), .stsWrData(stsWrData),
    .wcForce(wcForce), .peerActive(peerActive), .peerTime(peerTime),
    .status(status), .streamIrq(streamIrq), .xferGrant(xferGrant),
    .periodFrames(periodFrames), .periodStart(periodStart), .wallClk(wallClk)
  );

  task automatic check(input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, actual, expected);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendFrames(input int n, input bit ioc);
    frameValid = 1'b1; frameInc = 4'(n); descDone = ioc; descIoc = ioc;
    step();
    frameValid = 1'b0; frameInc = '0; descDone = 1'b0; descIoc = 1'b0;
  endtask

  task automatic writeSts(input logic [2:0] d);
    stsWrEn = 1'b1; stsWrData = d;
    step();
    stsWrEn = 1'b0; stsWrData = '0;
  endtask

  task automatic testReset();
    check("R1 reset status", int'(status), 0);
    check("R10 reset irq", int'(streamIrq), 0);
    check("R8 reset grant", int'(xferGrant), 0);
    check("R7 reset wall clock", int'(wallClk), 0);
  endtask

  task automatic testEnable();
    runEn = 1'b1; step();
    check("R6 frames after enable", int'(periodFrames), 0);
    check("R6 start after enable", int'(periodStart), 0);
    check("R8 grant while running", int'(xferGrant), 1);
  endtask

  task automatic testPlainRoll();
    sendFrames(4, 0);
    check("R8 frames counted", int'(periodFrames), 4);
    sendFrames(4, 0);
    check("R8 grant low when full", int'(xferGrant), 0);
    step();
    check("R5 frames after roll", int'(periodFrames), 0);
    check("R5 wall clock committed", int'(wallClk), 16);
    check("R5 new start stamp", int'(periodStart), 16);
    check("R3 no bufcmp without ioc", int'(status), 0);
  endtask

  task automatic testIocPeriod();
    sendFrames(4, 1);
    check("R3 no bufcmp after descriptor", int'(status[0]), 0);
    sendFrames(4, 0);
    check("R3 no bufcmp before eval", int'(status[0]), 0);
    step();
    check("R4 bufcmp at period end", int'(status[0]), 1);
    check("R10 irq from bufcmp", int'(streamIrq), 1);
    check("R7 wall clock advanced", int'(wallClk), 32);
    sendFrames(3, 0);
    step(); step();
    check("R8 closed period ignores frames", int'(periodFrames), 8);
    check("R8 no grant while closed", int'(xferGrant), 0);
    writeSts(3'b000);
    check("R1 zero write keeps bufcmp", int'(status[0]), 1);
    writeSts(3'b001);
    check("R1 bufcmp cleared", int'(status[0]), 0);
    check("R9 new period frames", int'(periodFrames), 0);
    check("R9 new period start", int'(periodStart), 32);
    check("R9 grant back", int'(xferGrant), 1);
  endtask

  task automatic testPeerBlock();
    peerActive = 2'b01; peerTime = {16'd0, 16'd10};
    sendFrames(4, 1); sendFrames(4, 0); step();
    check("R4 blocked no bufcmp", int'(status[0]), 0);
    check("R4 blocked no irq", int'(streamIrq), 0);
    check("R7 blocked wall clock", int'(wallClk), 32);
    check("R8 blocked no grant", int'(xferGrant), 0);
    peerTime = {16'd0, 16'd100}; step();
    check("R7 peer passed commit", int'(wallClk), 48);
    check("R4 bufcmp after commit", int'(status[0]), 1);
    writeSts(3'b001);
    check("R9 start after peer case", int'(periodStart), 48);
    peerTime = {16'd0, 16'd10}; wcForce = 1'b1;
    sendFrames(4, 1); sendFrames(4, 0); step();
    check("R7 forced commit", int'(wallClk), 64);
    check("R4 bufcmp forced", int'(status[0]), 1);
    writeSts(3'b001);
    wcForce = 1'b0; peerActive = '0;
  endtask

  task automatic testIocDisabled();
    iocEn = 1'b0;
    sendFrames(4, 1); sendFrames(4, 0); step();
    check("R2 no pending without enable", int'(status[0]), 0);
    check("R2 rolled over", int'(periodFrames), 0);
    check("R5 wall clock after roll", int'(wallClk), 80);
    iocEn = 1'b1;
  endtask

  task automatic testErrors();
    fifoErrEn = 1'b1; fifoErrEvt = 1'b1; step(); fifoErrEvt = 1'b0;
    check("R11 fifo error set", int'(status[1]), 1);
    check("R10 fifo irq", int'(streamIrq), 1);
    writeSts(3'b010);
    check("R1 fifo cleared", int'(status[1]), 0);
    check("R10 irq dropped", int'(streamIrq), 0);
    descErrEvt = 1'b1; step(); descErrEvt = 1'b0;
    check("R11 desc error set", int'(status[2]), 1);
    check("R10 masked desc error", int'(streamIrq), 0);
    stsWrEn = 1'b1; stsWrData = 3'b100; descErrEvt = 1'b1; step();
    stsWrEn = 1'b0; stsWrData = '0; descErrEvt = 1'b0;
    check("R1 event beats clear", int'(status[2]), 1);
    writeSts(3'b100);
    check("R1 desc cleared", int'(status[2]), 0);
  endtask

  task automatic testRunLowClear();
    sendFrames(4, 1); sendFrames(4, 0); step();
    check("R4 bufcmp before stop", int'(status[0]), 1);
    runEn = 1'b0; step();
    writeSts(3'b001);
    check("R9 run low clears bit", int'(status[0]), 0);
    check("R9 run low no restart", int'(periodFrames), 8);
    check("R8 no grant when stopped", int'(xferGrant), 0);
    runEn = 1'b1; step();
    check("R6 restart frames", int'(periodFrames), 0);
    check("R6 restart stamp", int'(periodStart), 96);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; runEn = 0; iocEn = 1; fifoErrEn = 0; descErrEn = 0;
    frameValid = 0; frameInc = '0; descDone = 0; descIoc = 0;
    fifoErrEvt = 0; descErrEvt = 0; stsWrEn = 0; stsWrData = '0;
    wcForce = 0; peerActive = '0; peerTime = '0;
    step(); step();
    rstN = 1'b1; step();
    testReset();
    testEnable();
    testPlainRoll();
    testIocPeriod();
    testPeerBlock();
    testIocDisabled();
    testErrors();
    testRunLowClear();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule